// File: doc/BRIEF.md
# Multiplexed Spark Channel Sequencer

This block drives a bank of ignition coil outputs from a small number of shared pulse engines. The output bank holds `NUM_CORES * CH_PER_CORE` channels. Each engine (a "core") owns an interleaved subset of those channels and serves them one at a time, in rising crank-angle order. Each channel has an enable, an end position and a cutoff position, and all channels share one dwell angle. A core drives its selected channel while the crank position lies in the dwell window that ends at that channel's end position. When the crank position reaches the selected channel's cutoff, the core moves on to its next channel. Every core also limits how long a single pulse may stay on, counted in clock cycles.

Two modes sit downstream of the cores. In the paired-coil (wasted-spark) mode, logical pulse `i` and logical pulse `i + N/2` both drive physical output `i`, and the upper half of the outputs stays off. A thermal gate with hysteresis, fed by a board temperature code, forces every output off while the board is too hot. A separate advisory flag compares the requested dwell time against the shortest dwell window that the multiplex factor allows at a supplied top engine speed. The engine speed is in rpm and the engine is `STROKE`-stroke.

Top module: `spk_mux_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `spark_out`, `over_temp` and `dwell_warn` are 0, and every core has its first channel selected. Core `c` starts on logical channel `c`.
- R2: Channels are interleaved across cores. Core `c` (0-based) serves logical channels `c`, `c+NUM_CORES`, `c+2*NUM_CORES` and so on, in that order.
- R3: Take the selected, enabled channel of a core. One cycle after `crank_pos` lies in `[end - dwell_cat, end)`, bit `ch` of `spark_out` is 1. It is 0 once `crank_pos` leaves that range. The window start saturates at 0.
- R4: A core advances to its next channel on the cycle when `crank_pos` changes to a value equal to the selected channel's cutoff. After its last channel the core wraps back to its first.
- R5: At any time, at most one of the channels served by a single core is high. A channel not selected by its core is low.
- R6: A channel whose `chan_en` bit is 0 never drives its output.
- R7: A pulse stays on for at most `MAX_DWELL_CYC` consecutive cycles. It is then held off until the core's next cutoff, even if the position stays inside the window.
- R8: With `waste_mode` at 1 and an even channel count, output `i < N/2` is the OR of logical pulses `i` and `i+N/2`. Outputs `N/2` and above are 0.
- R9: `over_temp` becomes 1 the cycle after `temp_c > HOT_C`. It becomes 0 the cycle after `temp_c <= COOL_C`. For codes in between it holds its value.
- R10: While `over_temp` is 1, all of `spark_out` is 0. The gate takes effect on the same cycle that `over_temp` rises.
- R11: One cycle after its inputs, `dwell_warn` is 1 exactly when `dwell_us * 2 * CH_PER_CORE * max_rpm > 60_000_000 * STROKE`. That is, the requested dwell exceeds the minimum window in microseconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crank_pos | input | POS_W | Current crank angle in ticks |
| chan_en | input | NUM_OUT | Per-channel enable, bit = logical channel |
| chan_end | input | NUM_OUT*POS_W | Per-channel pulse end position, channel k at bits [k*POS_W +: POS_W] |
| chan_cutoff | input | NUM_OUT*POS_W | Per-channel cutoff position, same packing |
| dwell_cat | input | POS_W | Shared dwell length in crank ticks |
| waste_mode | input | 1 | Paired-coil folding mode |
| temp_c | input | TEMP_W | Board temperature code in degrees C |
| dwell_us | input | US_W | Requested dwell time in microseconds |
| max_rpm | input | RPM_W | Highest expected engine speed |
| spark_out | output | NUM_OUT | Coil driver commands |
| over_temp | output | 1 | Thermal shutdown active |
| dwell_warn | output | 1 | Requested dwell exceeds the multiplexed window |

## Verification
The properties assume that each channel's cutoff lies outside its own dwell window. They also assume that the windows of channels sharing a core do not overlap, so a pulse is never re-armed in the middle of a window. Without these conditions the per-output run-length bound would not hold. The stimulus always advances `crank_pos` in increasing order through windows that are spaced 100 ticks apart. Each cutoff sits 30 ticks past its end position, and position is held still only inside a single window. The folded-mode properties also assume that `waste_mode` only changes while all outputs are idle, which the bench respects by switching it only during reset.

// File: rtl/spk_pkg.sv
package spk_pkg;

   typedef enum logic {
      THERM_COOL = 1'b0,
      THERM_TRIP = 1'b1
   } therm_e;

   // logical channel index served by slot m of core c
   function automatic int chan_of(input int c, input int m, input int ncores);
      return c + m * ncores;
   endfunction

endpackage

// File: rtl/spk_core.sv
module spk_core #(
   parameter int MUX           = 4,
   parameter int POS_W         = 12,
   parameter int MAX_DWELL_CYC = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [POS_W-1:0]     pos,
   input  logic                 pos_moved,
   input  logic [MUX-1:0]       en_v,
   input  logic [MUX*POS_W-1:0] end_v,
   input  logic [MUX*POS_W-1:0] cut_v,
   input  logic [POS_W-1:0]     dwell,
   output logic [MUX-1:0]       drive_v
);

   localparam int PTR_W = (MUX > 1) ? $clog2(MUX) : 1;
   localparam int CNT_W = $clog2(MAX_DWELL_CYC + 1);

   logic [PTR_W-1:0] ptr;
   logic [POS_W-1:0] sel_end, sel_cut, win_lo;
   logic             sel_en, raw, drive, cut_hit, lock;
   logic [CNT_W-1:0] cnt;

   // selected channel fields
   always_comb begin
      sel_en  = 1'b0;
      sel_end = '0;
      sel_cut = '0;
      for (int m = 0; m < MUX; m++) begin
         if (ptr == PTR_W'(m)) begin
            sel_en  = en_v[m];
            sel_end = end_v[m*POS_W +: POS_W];
            sel_cut = cut_v[m*POS_W +: POS_W];
         end
      end
   end

   always_comb begin
      win_lo  = (dwell > sel_end) ? '0 : (sel_end - dwell);
      raw     = sel_en && (pos >= win_lo) && (pos < sel_end);
      drive   = raw && !lock;
      cut_hit = pos_moved && (pos == sel_cut);
   end

   generate
      if (MUX > 1) begin : g_rotate
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ptr <= '0;
            else if (cut_hit)
               ptr <= (ptr == PTR_W'(MUX - 1)) ? '0 : ptr + 1'b1;
         end
      end else begin : g_fixed
         assign ptr = '0;
      end
   endgenerate

   // dwell length guard
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock <= 1'b0;
         cnt  <= '0;
      end else if (cut_hit) begin
         lock <= 1'b0;
         cnt  <= '0;
      end else if (!raw) begin
         cnt  <= '0;
      end else if (drive) begin
         if (cnt == CNT_W'(MAX_DWELL_CYC - 1))
            lock <= 1'b1;
         cnt <= cnt + 1'b1;
      end
   end

   generate
      for (genvar m = 0; m < MUX; m++) begin : g_drv
         assign drive_v[m] = drive && (ptr == PTR_W'(m));
      end
   endgenerate

endmodule

// File: rtl/spk_thermal.sv
module spk_thermal #(
   parameter int TEMP_W = 8,
   parameter int HOT_C  = 85,
   parameter int COOL_C = 55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] temp,
   output logic              trip_next,
   output logic              trip
);
   import spk_pkg::*;

   therm_e state, state_nx;

   always_comb begin
      state_nx = state;
      case (state)
         THERM_COOL: if (temp > TEMP_W'(HOT_C))   state_nx = THERM_TRIP;
         THERM_TRIP: if (temp <= TEMP_W'(COOL_C)) state_nx = THERM_COOL;
         default:    state_nx = THERM_COOL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= THERM_COOL;
      else        state <= state_nx;
   end

   assign trip_next = (state_nx == THERM_TRIP);
   assign trip      = (state == THERM_TRIP);

endmodule

// File: rtl/spk_route.sv
module spk_route #(
   parameter int NUM_OUT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_OUT-1:0] pulse_l,
   input  logic               waste,
   input  logic               block,
   output logic [NUM_OUT-1:0] spark_out
);
   localparam int HALF = NUM_OUT / 2;

   logic [NUM_OUT-1:0] phys;

   generate
      if ((NUM_OUT % 2) == 0) begin : g_fold
         always_comb begin
            phys = pulse_l;
            if (waste) begin
               phys[HALF-1:0]       = pulse_l[HALF-1:0] | pulse_l[NUM_OUT-1:HALF];
               phys[NUM_OUT-1:HALF] = '0;
            end
         end
      end else begin : g_pass
         assign phys = pulse_l;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     spark_out <= '0;
      else if (block) spark_out <= '0;
      else            spark_out <= phys;
   end

endmodule

// File: rtl/spk_window.sv
module spk_window #(
   parameter int MUX    = 4,
   parameter int STROKE = 4,
   parameter int US_W   = 16,
   parameter int RPM_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [US_W-1:0]  dwell_us,
   input  logic [RPM_W-1:0] max_rpm,
   output logic             warn
);
   // dwell_us > 60e6*STROKE / (2*MUX*rpm), cross-multiplied
   localparam logic [63:0] LIMIT = 64'(60_000_000) * 64'(STROKE);

   logic [63:0] demand;

   assign demand = 64'(dwell_us) * 64'(max_rpm) * 64'(2 * MUX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) warn <= 1'b0;
      else        warn <= (demand > LIMIT);
   end

endmodule

// File: rtl/spk_mux_seq.sv
module spk_mux_seq #(
   parameter int NUM_CORES     = 2,
   parameter int CH_PER_CORE   = 4,
   parameter int POS_W         = 12,
   parameter int MAX_DWELL_CYC = 64,
   parameter int STROKE        = 4,
   parameter int TEMP_W        = 8,
   parameter int HOT_C         = 85,
   parameter int COOL_C        = 55,
   parameter int US_W          = 16,
   parameter int RPM_W         = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [POS_W-1:0]                 crank_pos,
   input  logic [NUM_CORES*CH_PER_CORE-1:0] chan_en,
   input  logic [NUM_CORES*CH_PER_CORE*POS_W-1:0] chan_end,
   input  logic [NUM_CORES*CH_PER_CORE*POS_W-1:0] chan_cutoff,
   input  logic [POS_W-1:0]                 dwell_cat,
   input  logic                             waste_mode,
   input  logic [TEMP_W-1:0]                temp_c,
   input  logic [US_W-1:0]                  dwell_us,
   input  logic [RPM_W-1:0]                 max_rpm,
   output logic [NUM_CORES*CH_PER_CORE-1:0] spark_out,
   output logic                             over_temp,
   output logic                             dwell_warn
);
   localparam int NUM_OUT = NUM_CORES * CH_PER_CORE;

   // elaboration-time parameter checks
   generate
      if (NUM_CORES < 1)       begin : g_bad_cores $error("NUM_CORES must be at least 1"); end
      if (CH_PER_CORE < 1)     begin : g_bad_mux   $error("CH_PER_CORE must be at least 1"); end
      if (MAX_DWELL_CYC < 1)   begin : g_bad_dwell $error("MAX_DWELL_CYC must be at least 1"); end
      if (COOL_C >= HOT_C)     begin : g_bad_hyst  $error("COOL_C must be below HOT_C"); end
      if (HOT_C >= (1 << TEMP_W)) begin : g_bad_temp $error("HOT_C does not fit TEMP_W"); end
      if (STROKE != 2 && STROKE != 4) begin : g_bad_stroke $error("STROKE must be 2 or 4"); end
   endgenerate

   logic [POS_W-1:0]   pos_q;
   logic               pos_moved;
   logic [NUM_OUT-1:0] pulse_l;
   logic               trip_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos_q <= '0;
      else        pos_q <= crank_pos;
   end

   assign pos_moved = (crank_pos != pos_q);

   generate
      for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
         logic [CH_PER_CORE-1:0]       en_c;
         logic [CH_PER_CORE*POS_W-1:0] end_c;
         logic [CH_PER_CORE*POS_W-1:0] cut_c;
         logic [CH_PER_CORE-1:0]       drv_c;

         for (genvar m = 0; m < CH_PER_CORE; m++) begin : g_slot
            localparam int CH = spk_pkg::chan_of(c, m, NUM_CORES);
            assign en_c[m]                  = chan_en[CH];
            assign end_c[m*POS_W +: POS_W]  = chan_end[CH*POS_W +: POS_W];
            assign cut_c[m*POS_W +: POS_W]  = chan_cutoff[CH*POS_W +: POS_W];
            assign pulse_l[CH]              = drv_c[m];
         end

         spk_core #(
            .MUX          (CH_PER_CORE),
            .POS_W        (POS_W),
            .MAX_DWELL_CYC(MAX_DWELL_CYC)
         ) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .pos      (crank_pos),
            .pos_moved(pos_moved),
            .en_v     (en_c),
            .end_v    (end_c),
            .cut_v    (cut_c),
            .dwell    (dwell_cat),
            .drive_v  (drv_c)
         );
      end
   endgenerate

   spk_thermal #(
      .TEMP_W(TEMP_W),
      .HOT_C (HOT_C),
      .COOL_C(COOL_C)
   ) u_therm (
      .clk      (clk),
      .rst_n    (rst_n),
      .temp     (temp_c),
      .trip_next(trip_next),
      .trip     (over_temp)
   );

   spk_route #(
      .NUM_OUT(NUM_OUT)
   ) u_route (
      .clk      (clk),
      .rst_n    (rst_n),
      .pulse_l  (pulse_l),
      .waste    (waste_mode),
      .block    (trip_next),
      .spark_out(spark_out)
   );

   spk_window #(
      .MUX   (CH_PER_CORE),
      .STROKE(STROKE),
      .US_W  (US_W),
      .RPM_W (RPM_W)
   ) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .dwell_us(dwell_us),
      .max_rpm (max_rpm),
      .warn    (dwell_warn)
   );

endmodule

// File: rtl/spk_mux_seq_chk.sv
module spk_mux_seq_chk #(
   parameter int NUM_CORES     = 2,
   parameter int CH_PER_CORE   = 4,
   parameter int POS_W         = 12,
   parameter int MAX_DWELL_CYC = 64,
   parameter int STROKE        = 4,
   parameter int TEMP_W        = 8,
   parameter int HOT_C         = 85,
   parameter int COOL_C        = 55,
   parameter int US_W          = 16,
   parameter int RPM_W         = 16
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [NUM_CORES*CH_PER_CORE-1:0] chan_en,
   input logic                             waste_mode,
   input logic [TEMP_W-1:0]                temp_c,
   input logic [NUM_CORES*CH_PER_CORE-1:0] spark_out,
   input logic                             over_temp
);
   localparam int N     = NUM_CORES * CH_PER_CORE;
   localparam int RUN_W = $clog2(MAX_DWELL_CYC + 2);

   AST_THERMAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      over_temp |-> (spark_out == '0));                                  // R10
   AST_THERMAL_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_c > TEMP_W'(HOT_C)) |=> over_temp);                          // R9
   AST_THERMAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_c <= TEMP_W'(COOL_C)) |=> !over_temp);                       // R9
   AST_THERMAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_c > TEMP_W'(COOL_C) && temp_c <= TEMP_W'(HOT_C)) |=> $stable(over_temp)); // R9

   generate
      for (genvar c = 0; c < NUM_CORES; c++) begin : g_grp
         logic [CH_PER_CORE-1:0] grp;
         for (genvar m = 0; m < CH_PER_CORE; m++) begin : g_bit
            assign grp[m] = spark_out[c + m*NUM_CORES];
         end
         AST_ONE_PER_CORE: assert property (@(posedge clk) disable iff (!rst_n)
            !waste_mode |=> $onehot0(grp));                              // R5
      end

      for (genvar i = 0; i < N; i++) begin : g_run
         logic [RUN_W-1:0] run;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 run <= '0;
            else if (!spark_out[i])     run <= '0;
            else if (run <= RUN_W'(MAX_DWELL_CYC)) run <= run + 1'b1;
         end
         AST_NO_LONG_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
            run <= RUN_W'(MAX_DWELL_CYC));                               // R7
         AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (!chan_en[i] && !waste_mode) |=> !spark_out[i]);             // R6
      end

      if ((N % 2) == 0) begin : g_fold_chk
         AST_FOLD_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            waste_mode |=> (spark_out[N-1:N/2] == '0));                  // R8
      end
   endgenerate

endmodule

bind spk_mux_seq spk_mux_seq_chk #(
   .NUM_CORES    (NUM_CORES),
   .CH_PER_CORE  (CH_PER_CORE),
   .POS_W        (POS_W),
   .MAX_DWELL_CYC(MAX_DWELL_CYC),
   .STROKE       (STROKE),
   .TEMP_W       (TEMP_W),
   .HOT_C        (HOT_C),
   .COOL_C       (COOL_C),
   .US_W         (US_W),
   .RPM_W        (RPM_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .chan_en   (chan_en),
   .waste_mode(waste_mode),
   .temp_c    (temp_c),
   .spark_out (spark_out),
   .over_temp (over_temp)
);

// File: tb/spk_mux_seq_test.sv
module spk_mux_seq_test;

   localparam int NC    = 2;
   localparam int MUXF  = 4;
   localparam int N     = NC * MUXF;
   localparam int PW    = 12;
   localparam int MAXD  = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PW-1:0]   crank_pos = '0;
   logic [N-1:0]    chan_en = '1;
   logic [N*PW-1:0] chan_end = '0;
   logic [N*PW-1:0] chan_cutoff = '0;
   logic [PW-1:0]   dwell_cat = 12'd20;
   logic            waste_mode = 1'b0;
   logic [7:0]      temp_c = 8'd25;
   logic [15:0]     dwell_us = 16'd1000;
   logic [15:0]     max_rpm = 16'd6000;
   logic [N-1:0]    spark_out;
   logic            over_temp;
   logic            dwell_warn;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   spk_mux_seq #(
      .NUM_CORES(NC), .CH_PER_CORE(MUXF), .POS_W(PW), .MAX_DWELL_CYC(MAXD)
   ) uut (
      .clk(clk), .rst_n(rst_n), .crank_pos(crank_pos), .chan_en(chan_en),
      .chan_end(chan_end), .chan_cutoff(chan_cutoff), .dwell_cat(dwell_cat),
      .waste_mode(waste_mode), .temp_c(temp_c), .dwell_us(dwell_us),
      .max_rpm(max_rpm), .spark_out(spark_out), .over_temp(over_temp),
      .dwell_warn(dwell_warn)
   );

   // {position, expected outputs}; channel k window ends at 100*(k+1), cutoff 30 later
   localparam int NV = 22;
   localparam logic [PW+N-1:0] VEC [0:NV-1] = '{
      {12'd50,  8'h00}, {12'd80,  8'h01}, {12'd99,  8'h01}, {12'd100, 8'h00},
      {12'd130, 8'h00}, {12'd180, 8'h02}, {12'd199, 8'h02}, {12'd230, 8'h00},
      {12'd280, 8'h04}, {12'd330, 8'h00}, {12'd380, 8'h08}, {12'd430, 8'h00},
      {12'd480, 8'h10}, {12'd530, 8'h00}, {12'd580, 8'h20}, {12'd630, 8'h00},
      {12'd680, 8'h40}, {12'd730, 8'h00}, {12'd780, 8'h80}, {12'd830, 8'h00},
      {12'd80,  8'h01}, {12'd180, 8'h02}
   };

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic wmode);
      rst_n = 1'b0;
      crank_pos = '0;
      waste_mode = wmode;
      temp_c = 8'd25;
      tick();
      tick();
      rst_n = 1'b1;
   endtask

   task automatic walk_table(input logic folded);
      for (int v = 0; v < NV; v++) begin
         logic [N-1:0] e;
         crank_pos = VEC[v][PW+N-1:N];
         e = VEC[v][N-1:0];
         if (folded) e = {4'h0, e[3:0] | e[7:4]};
         tick();
         if (folded) chk(32'(spark_out), 32'(e), "R8 folded table");
         else        chk(32'(spark_out), 32'(e), "R2 R3 R4 R5 table");
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < N; k++) begin
         chan_end[k*PW +: PW]    = PW'(100 + 100 * k);
         chan_cutoff[k*PW +: PW] = PW'(130 + 100 * k);
      end

      // R1: reset state
      tick();
      chk(32'(spark_out), 0, "R1 spark_out in reset");
      chk(32'(over_temp), 0, "R1 over_temp in reset");
      chk(32'(dwell_warn), 0, "R1 dwell_warn in reset");
      rst_n = 1'b1;

      // R1: core 0 starts on channel 0, so channel 2 window gives nothing
      crank_pos = 12'd280; tick();
      chk(32'(spark_out), 0, "R1 core0 not yet on ch2");
      crank_pos = 12'd180; tick();
      chk(32'(spark_out), 32'h02, "R1 core1 starts on ch1");

      // R2 R3 R4 R5: sequential walk with wrap
      do_reset(1'b0);
      walk_table(1'b0);

      // R6: disabled channel stays quiet
      do_reset(1'b0);
      chan_en[0] = 1'b0;
      crank_pos = 12'd85; tick();
      chk(32'(spark_out), 0, "R6 disabled ch0");
      chan_en[0] = 1'b1;
      crank_pos = 12'd86; tick();
      chk(32'(spark_out), 32'h01, "R6 re-enabled ch0");

      // R3: window start saturates at zero
      do_reset(1'b0);
      dwell_cat = 12'd150;
      crank_pos = 12'd1; tick();
      chk(32'(spark_out), 32'h01, "R3 saturated window start");
      dwell_cat = 12'd20;

      // R7: max dwell guard
      do_reset(1'b0);
      crank_pos = 12'd90;
      repeat (MAXD) tick();
      chk(32'(spark_out), 32'h01, "R7 still on at limit");
      tick();
      chk(32'(spark_out), 0, "R7 off after limit");
      crank_pos = 12'd95; tick();
      chk(32'(spark_out), 0, "R7 stays off until cutoff");

      // R8: folded mode
      do_reset(1'b1);
      walk_table(1'b1);

      // R9 R10: thermal hysteresis and gate
      do_reset(1'b0);
      crank_pos = 12'd80; tick();
      chk(32'(spark_out), 32'h01, "R10 baseline pulse");
      temp_c = 8'd86; tick();
      chk(32'(over_temp), 1, "R9 trip above hot");
      chk(32'(spark_out), 0, "R10 outputs blocked");
      temp_c = 8'd60; tick();
      chk(32'(over_temp), 1, "R9 hold in band");
      chk(32'(spark_out), 0, "R10 still blocked");
      temp_c = 8'd55; tick();
      chk(32'(over_temp), 0, "R9 release at cool");
      chk(32'(spark_out), 32'h01, "R10 outputs restored");
      temp_c = 8'd85; tick();
      chk(32'(over_temp), 0, "R9 no trip at hot limit");

      // R11: dwell window advisory (MUX 4, 4-stroke)
      dwell_us = 16'd5000; max_rpm = 16'd6000; tick();
      chk(32'(dwell_warn), 0, "R11 equal to window");
      dwell_us = 16'd5001; tick();
      chk(32'(dwell_warn), 1, "R11 above window");
      dwell_us = 16'd9000; max_rpm = 16'd3000; tick();
      chk(32'(dwell_warn), 0, "R11 slower engine");
      dwell_us = 16'd10001; tick();
      chk(32'(dwell_warn), 1, "R11 slower engine over");

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule